// File: doc/BRIEF.md
# USB Endpoint NAK Flag and Data-Toggle Control

This block holds the endpoint-level control state of a small USB device function. It has one control endpoint (EP0) and three data endpoints (EP1-OUT, EP2-IN, EP3-IN). Software reaches it through two 8-bit registers on a 5-bit-address CPU bus. The serial interface engine reaches it through per-endpoint event strobes.

The NAK-flag register records sticky flags. The engine sets a flag whenever an IN endpoint answers a token with NAK, and the flag stays set until software clears it. The control register holds the per-endpoint traffic-disable bits and the self-clearing commands that force a data endpoint's toggle back to DATA0. The block also keeps the DATA0/DATA1 toggle of each data endpoint and flips it on each successful transaction. It drives the toggles and the disable bits back to the engine. A synchronous USB bus-reset input returns everything to its idle state.

Top module: `usb_ep_ctl`

## Requirements
- R1: After rst_ni is released, both registers read 00h, toggle_o reads 000 and ep_dis_o reads 000.
- R2: The NAK-flag register is at address 09h. nak_evt_i[0] (EP0-IN) sets bit 5, nak_evt_i[1] (EP2-IN) sets bit 6 and nak_evt_i[2] (EP3-IN) sets bit 7, at the next clock edge. A set flag stays set until software writes 0 to that bit.
- R3: If nak_evt_i sets a flag in the same cycle that software writes 0 to that flag, the flag ends up set.
- R4: The control register is at address 0Ah. Bits 5, 6 and 7 are the disable bits of EP1-OUT, EP2-IN and EP3-IN. They read back as written and drive ep_dis_o[0], ep_dis_o[1] and ep_dis_o[2].
- R5: Writing 1 to control bit 2, 3 or 4 (EP1-OUT, EP2-IN, EP3-IN) makes that bit read 1 for exactly the one cycle after the write and 0 after that. At the edge that ends that cycle, the matching toggle_o bit becomes 0 (DATA0).
- R6: toggle_o[0], toggle_o[1] and toggle_o[2] are the toggles of EP1-OUT, EP2-IN and EP3-IN. A pulse on xfer_ok_i[i] while the endpoint is enabled inverts toggle_o[i] at the next edge.
- R7: A toggle-clear in progress takes priority over a same-cycle xfer_ok_i on that endpoint. The toggle ends at 0.
- R8: While an endpoint's disable bit is 1, xfer_ok_i for that endpoint leaves its toggle unchanged.
- R9: bus_reset_i clears both registers and all toggles at the next edge. It overrides any same-cycle write and any engine event.
- R10: Bits 4..0 of the NAK-flag register and bits 1..0 of the control register read 0, and writes to them are ignored. Other addresses read 00h, and writes to them change nothing.
- R11: EP0 has no disable or toggle control. Its NAK flag is recorded whatever the control register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | Synchronous USB bus reset from the engine |
| addr_i | input | 5 | CPU register address |
| wr_en_i | input | 1 | CPU write strobe |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | CPU read data, combinational from addr_i |
| nak_evt_i | input | 3 | NAK answered on EP0-IN, EP2-IN, EP3-IN (bit 0..2) |
| xfer_ok_i | input | 3 | Successful transaction on EP1-OUT, EP2-IN, EP3-IN (bit 0..2) |
| toggle_o | output | 3 | Data toggles of EP1-OUT, EP2-IN, EP3-IN |
| ep_dis_o | output | 3 | Traffic-disable bits of EP1-OUT, EP2-IN, EP3-IN |

## Verification
The bench raises a NAK event in the same cycle as a software write of 0 to that flag. A design that let the write win would read 00h where 40h is expected. It times the toggle-clear strobe edge by edge: a strobe that lingered shows a stale 1 in the control register, and a clear that came a cycle late leaves the old toggle visible. It pulses xfer_ok_i during the strobe cycle, where a design that let the flip win ends with DATA1. It also pulses xfer_ok_i on disabled endpoints. It then checks that bus reset beats a simultaneous write and simultaneous events, and that reserved bits and unmapped addresses neither store nor return anything.

// File: rtl/usb_epctl_pkg.sv
package usb_epctl_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NUM_EP = 3;
  localparam logic [ADDR_W-1:0] NAK_ADDR = 5'h09;
  localparam logic [ADDR_W-1:0] CTL_ADDR = 5'h0A;
  // field positions that software decodes
  localparam int unsigned NAK_LSB = 5;
  localparam int unsigned DIS_LSB = 5;
  localparam int unsigned CLR_LSB = 2;
endpackage

// File: rtl/epctl_nak_flags.sv
module epctl_nak_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bus_reset_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  // engine set beats software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flags_q <= '0;
    else if (bus_reset_i) flags_q <= '0;
    else                  flags_q <= (wr_i ? wdata_i : flags_q) | evt_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/epctl_ctl_reg.sv
module epctl_ctl_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bus_reset_i,
  input  logic         wr_i,
  input  logic [N-1:0] dis_wdata_i,
  input  logic [N-1:0] clr_wdata_i,
  output logic [N-1:0] dis_o,
  output logic [N-1:0] clr_o
);
  logic [N-1:0] dis_q;
  logic [N-1:0] clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= '0;
      clr_q <= '0;
    end else if (bus_reset_i) begin
      dis_q <= '0;
      clr_q <= '0;
    end else begin
      if (wr_i) dis_q <= dis_wdata_i;
      // one-cycle strobe
      clr_q <= wr_i ? clr_wdata_i : '0;
    end
  end

  assign dis_o = dis_q;
  assign clr_o = clr_q;
endmodule

// File: rtl/epctl_toggle_bank.sv
module epctl_toggle_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bus_reset_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ok_i,
  input  logic [N-1:0] dis_i,
  output logic [N-1:0] tog_o
);
  for (genvar i = 0; i < N; i++) begin : g_ep
    logic tog_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      tog_q <= 1'b0;
      else if (bus_reset_i || clr_i[i]) tog_q <= 1'b0;
      else if (ok_i[i] && !dis_i[i])    tog_q <= ~tog_q;
    end
    assign tog_o[i] = tog_q;
  end
endmodule

// File: rtl/usb_ep_ctl.sv
module usb_ep_ctl
  import usb_epctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_reset_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_EP-1:0] nak_evt_i,
  input  logic [NUM_EP-1:0] xfer_ok_i,
  output logic [NUM_EP-1:0] toggle_o,
  output logic [NUM_EP-1:0] ep_dis_o
);
  logic              wr_nak, wr_ctl;
  logic [NUM_EP-1:0] nak_q, dis_q, clr_q;
  logic              unused_wbits;

  assign wr_nak = wr_en_i && (addr_i == NAK_ADDR);
  assign wr_ctl = wr_en_i && (addr_i == CTL_ADDR);
  assign unused_wbits = ^wdata_i[CLR_LSB-1:0];

  epctl_nak_flags #(.N(NUM_EP)) u_nak (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .wr_i        (wr_nak),
    .wdata_i     (wdata_i[NAK_LSB +: NUM_EP]),
    .evt_i       (nak_evt_i),
    .flags_o     (nak_q)
  );

  epctl_ctl_reg #(.N(NUM_EP)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .wr_i        (wr_ctl),
    .dis_wdata_i (wdata_i[DIS_LSB +: NUM_EP]),
    .clr_wdata_i (wdata_i[CLR_LSB +: NUM_EP]),
    .dis_o       (dis_q),
    .clr_o       (clr_q)
  );

  epctl_toggle_bank #(.N(NUM_EP)) u_tog (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .clr_i       (clr_q),
    .ok_i        (xfer_ok_i),
    .dis_i       (dis_q),
    .tog_o       (toggle_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == NAK_ADDR) begin
      rdata_o[NAK_LSB +: NUM_EP] = nak_q;
    end else if (addr_i == CTL_ADDR) begin
      rdata_o[DIS_LSB +: NUM_EP] = dis_q;
      rdata_o[CLR_LSB +: NUM_EP] = clr_q;
    end
  end

  assign ep_dis_o = dis_q;
endmodule

// File: rtl/usb_ep_ctl_chk.sv
module usb_ep_ctl_chk
  import usb_epctl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_reset_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NUM_EP-1:0] nak_evt_i,
  input logic [NUM_EP-1:0] toggle_o,
  input logic [NUM_EP-1:0] ep_dis_o,
  input logic [NUM_EP-1:0] nak_q,
  input logic [NUM_EP-1:0] clr_q
);
  AST_NAK_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|nak_evt_i && !bus_reset_i) |=> ((nak_q & $past(nak_evt_i)) == $past(nak_evt_i))); // R3

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_q && !(wr_en_i && addr_i == CTL_ADDR)) |=> (clr_q == '0)); // R5

  AST_CLEAR_TO_DATA0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_q) |=> ((toggle_o & $past(clr_q)) == '0)); // R7

  AST_DISABLED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_reset_i |=> (((toggle_o ^ $past(toggle_o)) & $past(ep_dis_o & ~clr_q)) == '0)); // R8

  AST_BUS_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (nak_q == '0 && clr_q == '0 && toggle_o == '0 && ep_dis_o == '0)); // R9

  AST_NAK_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == NAK_ADDR) |-> (rdata_o[NAK_LSB-1:0] == '0)); // R10

  AST_CTL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == CTL_ADDR) |-> (rdata_o[CLR_LSB-1:0] == '0)); // R10
endmodule

bind usb_ep_ctl usb_ep_ctl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_reset_i (bus_reset_i),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .rdata_o     (rdata_o),
  .nak_evt_i   (nak_evt_i),
  .toggle_o    (toggle_o),
  .ep_dis_o    (ep_dis_o),
  .nak_q       (nak_q),
  .clr_q       (clr_q)
);

// File: tb/tb_usb_ep_ctl.sv
`timescale 1ns/1ps
module tb_usb_ep_ctl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_reset_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [2:0] nak_evt_i = '0;
  logic [2:0] xfer_ok_i = '0;
  logic [2:0] toggle_o;
  logic [2:0] ep_dis_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  usb_ep_ctl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_reset_i(bus_reset_i),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .nak_evt_i(nak_evt_i), .xfer_ok_i(xfer_ok_i),
    .toggle_o(toggle_o), .ep_dis_o(ep_dis_o)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic pulse_nak(input logic [2:0] v);
    nak_evt_i = v; tick(); nak_evt_i = '0;
  endtask

  task automatic pulse_ok(input logic [2:0] v);
    xfer_ok_i = v; tick(); xfer_ok_i = '0;
  endtask

  task automatic t_reset;
    rd_chk("R1 nak reg", 5'h09, 8'h00);
    rd_chk("R1 ctl reg", 5'h0A, 8'h00);
    chk("R1 toggles", {5'd0, toggle_o}, 8'h00);
    chk("R1 disables", {5'd0, ep_dis_o}, 8'h00);
  endtask

  task automatic t_nak_flags;
    pulse_nak(3'b001);
    rd_chk("R2 ep0 flag bit5", 5'h09, 8'h20);
    pulse_nak(3'b110);
    rd_chk("R2 ep2 ep3 flags", 5'h09, 8'hE0);
    tick(); tick();
    rd_chk("R2 flags sticky", 5'h09, 8'hE0);
    wr(5'h09, 8'h60);
    rd_chk("R2 clear ep3 only", 5'h09, 8'h60);
    wr(5'h09, 8'h00);
    rd_chk("R2 clear all", 5'h09, 8'h00);
  endtask

  task automatic t_nak_race;
    nak_evt_i = 3'b010;
    wr(5'h09, 8'h00);
    nak_evt_i = '0;
    rd_chk("R3 set beats clear", 5'h09, 8'h40);
    wr(5'h09, 8'h00);
  endtask

  task automatic t_toggle;
    pulse_ok(3'b101);
    chk("R6 flip ep1 ep3", {5'd0, toggle_o}, 8'h05);
    pulse_ok(3'b011);
    chk("R6 flip ep1 ep2", {5'd0, toggle_o}, 8'h06);
    wr(5'h0A, 8'h08);
    rd_chk("R5 strobe visible", 5'h0A, 8'h08);
    chk("R5 toggle before strobe edge", {5'd0, toggle_o}, 8'h06);
    tick();
    rd_chk("R5 strobe self-clears", 5'h0A, 8'h00);
    chk("R5 ep2 toggle DATA0", {5'd0, toggle_o}, 8'h04);
    wr(5'h0A, 8'h1C);
    tick();
    chk("R5 all toggles DATA0", {5'd0, toggle_o}, 8'h00);
  endtask

  task automatic t_priority;
    wr(5'h0A, 8'h04);
    xfer_ok_i = 3'b011;
    tick();
    xfer_ok_i = '0;
    chk("R7 clear beats flip", {5'd0, toggle_o}, 8'h02);
    wr(5'h0A, 8'h08);
    tick();
  endtask

  task automatic t_disable;
    pulse_ok(3'b100);
    wr(5'h0A, 8'hE0);
    rd_chk("R4 disables read back", 5'h0A, 8'hE0);
    chk("R4 ep_dis_o all", {5'd0, ep_dis_o}, 8'h07);
    pulse_ok(3'b111);
    chk("R8 disabled toggles hold", {5'd0, toggle_o}, 8'h04);
    pulse_nak(3'b001);
    rd_chk("R11 ep0 nak recorded", 5'h09, 8'h20);
    wr(5'h09, 8'h00);
    wr(5'h0A, 8'h40);
    chk("R4 ep2 only disabled", {5'd0, ep_dis_o}, 8'h02);
    pulse_ok(3'b111);
    chk("R8 ep2 held others flip", {5'd0, toggle_o}, 8'h01);
    wr(5'h0A, 8'h00);
  endtask

  task automatic t_reserved;
    wr(5'h09, 8'hFF);
    rd_chk("R10 nak reserved bits", 5'h09, 8'hE0);
    wr(5'h0A, 8'h03);
    rd_chk("R10 ctl reserved bits", 5'h0A, 8'h00);
    chk("R10 toggles untouched", {5'd0, toggle_o}, 8'h01);
    wr(5'h05, 8'hFF);
    rd_chk("R10 unmapped reads zero", 5'h05, 8'h00);
    rd_chk("R10 nak unchanged", 5'h09, 8'hE0);
    rd_chk("R10 ctl unchanged", 5'h0A, 8'h00);
  endtask

  task automatic t_bus_reset;
    wr(5'h0A, 8'hE0);
    nak_evt_i = 3'b111;
    xfer_ok_i = 3'b111;
    bus_reset_i = 1'b1;
    wr(5'h0A, 8'hFC);
    nak_evt_i = '0; xfer_ok_i = '0; bus_reset_i = 1'b0;
    rd_chk("R9 nak cleared", 5'h09, 8'h00);
    rd_chk("R9 ctl cleared", 5'h0A, 8'h00);
    chk("R9 toggles DATA0", {5'd0, toggle_o}, 8'h00);
    chk("R9 enables restored", {5'd0, ep_dis_o}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_nak_flags();
    t_nak_race();
    t_toggle();
    t_priority();
    t_disable();
    t_reserved();
    t_bus_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule